// File: doc/BRIEF.md
# Event Flag, Interrupt Vector and DMA Request Unit

This unit keeps the sticky event flags of a register-mapped two-wire serial bus master and turns them into requests for the host. Logic elsewhere in the controller reports events with single-cycle pulses on a 16-bit set bus. Each pulse sets the matching flag, and the flag stays set until the host clears it. The low six flags are combined with a six-bit enable mask to drive one level interrupt line. The receive-ready and transmit-ready flags can also drive two DMA request lines.

The host reaches four 16-bit registers over a simple port with an address, a read strobe and a write strobe. Read data is combinational while the read strobe is high. Any side effect of a read takes place at the clock edge that ends that strobe cycle. A vector register lets an interrupt handler find and acknowledge the next pending source in one access. When DMA service is switched on for a direction, the matching interrupt enable is dropped so that the two paths do not both serve the same event.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset every register reads 0 at its address (status 0, enable 1, vector 2, DMA config 3; other addresses read 0), and irq, dma_rx_req and dma_tx_req are 0.
- R2: A 1 on set_pulse sets a status flag at bits 1 (no-ack), 2 (access ready), 3 (receive ready), 4 (transmit ready), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun) or 15 (single byte). The flag stays set afterwards. Every other stored bit reads 0.
- R3: A status read returns bus_busy at bit 12.
- R4: A write to the status address clears each of bits 5:0 where the written bit is 1. Bits 15:6 are unaffected.
- R5: When a set pulse and a host clear (write-one-to-clear or vector read) hit the same flag in the same cycle, the flag ends set.
- R6: A write to the enable address keeps only wdata[5:0]. Bits 15:6 read 0.
- R7: irq is 1 exactly when some bit of status[5:0] AND enable is 1.
- R8: A vector read returns k+1, where k is the lowest bit set in status[5:0] AND enable, or 0 if no such bit is set. The read clears flag k only.
- R9: A write to the DMA config address keeps only bit 15 (receive DMA on) and bit 7 (transmit DMA on).
- R10: A DMA config write with bit 15 set clears enable bit 3. A DMA config write with bit 7 set clears enable bit 4. A 0 in either bit leaves the enable unchanged.
- R11: dma_rx_req equals status bit 3 while receive DMA is on, and is 0 otherwise. dma_tx_req equals status bit 4 while transmit DMA is on, and is 0 otherwise.
- R12: Read side effects happen only when rd_en is 1, once per strobe cycle. Reads of other addresses and writes to the vector address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high |
| set_pulse | input | 16 | One-cycle event pulses, one per flag position |
| bus_busy | input | 1 | Bus-busy level shown in status reads |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the unit with its default six-bit enable field and a two-bit address. At that size every enable mask can be combined with every pattern of the four low event flags that exist. That covers all 1024 pairings of mask and pending set for the interrupt level, the vector priority and the single-flag clear that a vector read performs. Directed steps cover the cases the sweep does not reach: a set pulse colliding with a clear, strobe-less reads, writes to the read-only vector address, and DMA enables dropping interrupt enables.

// File: rtl/i2c_evt_pkg.sv
// Package: shared address map and flag layout of the event/interrupt unit.
// Assumes a 16-bit host data path and a 2-bit register address.
package i2c_evt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_VEC  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DMA  = 2'd3;

    // Flags that exist as storage.
    localparam logic [DATA_W-1:0] STAT_IMPL = 16'h8E1E;
    // Bits the host may clear by writing one.
    localparam logic [DATA_W-1:0] STAT_W1C  = 16'h003F;
    // Bits kept by the DMA configuration register.
    localparam logic [DATA_W-1:0] DMA_KEEP  = 16'h8080;

    localparam int BIT_RXRDY = 3;
    localparam int BIT_TXRDY = 4;
    localparam int BIT_BUSY  = 12;
    localparam int DMA_RX_EN = 15;
    localparam int DMA_TX_EN = 7;
endpackage

// File: rtl/i2c_evt_flags.sv
// Sticky flag bank. Each implemented bit is set by a pulse and cleared by
// either clear vector. A set in the same cycle as a clear wins.
// Assumes IMPL marks which bit positions hold storage.
module i2c_evt_flags #(
    parameter int W = 16,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_host_i,
    input  logic [W-1:0] clr_vec_i,
    output logic [W-1:0] flags_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (IMPL[g]) begin : g_store
            logic q;
            // Per-bit sticky register, set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (set_i[g])
                    q <= 1'b1;
                else if (clr_host_i[g] || clr_vec_i[g])
                    q <= 1'b0;
            end
            assign flags_o[g] = q;
        end else begin : g_none
            assign flags_o[g] = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_evt_vec.sv
// Priority encoder for the vector register. Finds the lowest pending
// enabled source and returns its 1-based index and a one-hot clear.
// Assumes N is small enough for a linear scan.
module i2c_evt_vec #(
    parameter int N  = 6,
    parameter int VW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend_i,
    output logic [VW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o    = VW'(i + 1);
                onehot_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/i2c_evt_cfg.sv
// Enable mask and DMA configuration registers. A DMA enable written as one
// drops the matching interrupt enable in the same cycle.
// Assumes at most one host write per cycle.
module i2c_evt_cfg
    import i2c_evt_pkg::*;
#(
    parameter int IE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              dma_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [IE_W-1:0]   mask_o,
    output logic [DATA_W-1:0] dma_o
);
    // Enable mask: loaded by its own write, trimmed by DMA enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (mask_we) begin
            mask_o <= wdata[IE_W-1:0];
        end else if (dma_we) begin
            if (wdata[DMA_RX_EN]) mask_o[BIT_RXRDY] <= 1'b0;
            if (wdata[DMA_TX_EN]) mask_o[BIT_TXRDY] <= 1'b0;
        end
    end

    // DMA configuration: only the two enable bits are retained.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_o <= '0;
        else if (dma_we)
            dma_o <= wdata & DMA_KEEP;
    end
endmodule

// File: rtl/i2c_evt_irq_unit.sv
// Top of the event/interrupt unit: host register decode, flag bank,
// enable and DMA configuration, vector encoder and request outputs.
// Assumes rd_en and wr_en are never high together.
module i2c_evt_irq_unit
    import i2c_evt_pkg::*;
#(
    parameter int IE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] set_pulse,
    input  logic              bus_busy,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    localparam int VW = $clog2(IE_W + 1);

    logic [DATA_W-1:0] st_q;
    logic [IE_W-1:0]   mask_q;
    logic [DATA_W-1:0] dma_q;
    logic [IE_W-1:0]   pend;
    logic [VW-1:0]     vec_idx;
    logic [IE_W-1:0]   vec_oh;
    logic [DATA_W-1:0] clr_host;
    logic [DATA_W-1:0] clr_vec;
    logic              vec_rd;

    // Host strobes decoded per register.
    assign vec_rd   = rd_en && (addr == A_VEC);
    assign clr_host = (wr_en && addr == A_STAT) ? (wdata & STAT_W1C) : '0;
    assign clr_vec  = vec_rd ? DATA_W'(vec_oh) : '0;

    i2c_evt_flags #(.W(DATA_W), .IMPL(STAT_IMPL)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_pulse & STAT_IMPL),
        .clr_host_i (clr_host),
        .clr_vec_i  (clr_vec),
        .flags_o    (st_q)
    );

    i2c_evt_cfg #(.IE_W(IE_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr_en && addr == A_MASK),
        .dma_we  (wr_en && addr == A_DMA),
        .wdata   (wdata),
        .mask_o  (mask_q),
        .dma_o   (dma_q)
    );

    assign pend = st_q[IE_W-1:0] & mask_q;

    i2c_evt_vec #(.N(IE_W), .VW(VW)) u_vec (
        .pend_i   (pend),
        .idx_o    (vec_idx),
        .onehot_o (vec_oh)
    );

    // Request outputs.
    assign irq        = |pend;
    assign dma_rx_req = dma_q[DMA_RX_EN] & st_q[BIT_RXRDY];
    assign dma_tx_req = dma_q[DMA_TX_EN] & st_q[BIT_TXRDY];

    // Read multiplexer, combinational while rd_en is high.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_STAT: begin
                    rdata           = st_q;
                    rdata[BIT_BUSY] = bus_busy;
                end
                A_MASK:  rdata = DATA_W'(mask_q);
                A_VEC:   rdata = DATA_W'(vec_idx);
                A_DMA:   rdata = dma_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_evt_irq_unit_chk.sv
// Checker for the event/interrupt unit, attached by bind below.
// Assumes the default IE_W of 6.
module i2c_evt_irq_unit_chk
    import i2c_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] set_pulse,
    input logic              bus_busy,
    input logic              irq,
    input logic              dma_rx_req,
    input logic              dma_tx_req,
    input logic [DATA_W-1:0] st_q,
    input logic [5:0]        mask_q,
    input logic [DATA_W-1:0] dma_q,
    input logic [5:0]        vec_oh
);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[2] |=> st_q[2]);

    a_r3_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT) |-> (rdata[BIT_BUSY] == bus_busy));

    a_r6_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_MASK) |-> (rdata[15:6] == 10'd0));

    a_r9_dma_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_DMA) |-> ((rdata & ~DMA_KEEP) == 16'd0));

    a_r10_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DMA && wdata[DMA_RX_EN]) |=> !mask_q[BIT_RXRDY]);

    a_r11_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (dma_q[DMA_RX_EN] && st_q[BIT_RXRDY]));

    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != 6'd0));

    a_r8_vec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_VEC && (set_pulse[5:0] & vec_oh) == 6'd0)
        |=> ((st_q[5:0] & $past(vec_oh)) == 6'd0));

    a_r12_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en && set_pulse == 16'd0) |=> $stable(st_q));
endmodule

bind i2c_evt_irq_unit i2c_evt_irq_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .set_pulse  (set_pulse),
    .bus_busy   (bus_busy),
    .irq        (irq),
    .dma_rx_req (dma_rx_req),
    .dma_tx_req (dma_tx_req),
    .st_q       (st_q),
    .mask_q     (mask_q),
    .dma_q      (dma_q),
    .vec_oh     (vec_oh)
);

// File: tb/tb_i2c_evt_irq_unit.sv
module tb_i2c_evt_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] set_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        irq, dma_rx_req, dma_tx_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    i2c_evt_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .set_pulse(set_pulse),
        .bus_busy(bus_busy), .irq(irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] p);
        @(negedge clk);
        set_pulse = p;
        @(negedge clk);
        set_pulse = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", v, 16'h0);
        end
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 dma", {14'd0, dma_rx_req, dma_tx_req}, 16'd0);

        // R2 only implemented flags hold, R4 high flags survive W1C
        pulse(16'hFFFF);
        rd(2'd0, v);
        chk("R2", v, 16'h8E1E);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v);
        chk("R4", v, 16'h8E00);

        // R5 set and host clear in the same cycle
        @(negedge clk);
        addr = 2'd0; wdata = 16'h003F; wr_en = 1'b1; set_pulse = 16'h0004;
        @(negedge clk);
        wr_en = 1'b0; set_pulse = '0;
        rd(2'd0, v);
        chk("R5", v, 16'h8E04);

        // R5 set and vector clear in the same cycle
        wr(2'd1, 16'h0004);
        @(negedge clk);
        addr = 2'd2; rd_en = 1'b1; set_pulse = 16'h0004;
        #1 chk("R8 vec", rdata, 16'd3);
        @(negedge clk);
        rd_en = 1'b0; set_pulse = '0;
        rd(2'd0, v);
        chk("R5 vec", v, 16'h8E04);

        // R12 no strobe, vector address write ignored
        @(negedge clk);
        addr = 2'd2;
        @(negedge clk);
        wr(2'd2, 16'hFFFF);
        rd(2'd0, v);
        chk("R12", v, 16'h8E04);
        rd(2'd1, v);
        chk("R12 mask", v, 16'h0004);
        rd(2'd2, v);
        chk("R12 vec", v, 16'd3);

        // Sweep: every enable mask against every low-flag pattern
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 16; s++) begin
                logic [5:0] sb, pend, oh;
                logic [15:0] ev;
                sb = 6'(s << 1);
                wr(2'd0, 16'h003F);
                pulse({10'd0, sb});
                wr(2'd1, {10'(m * 37 + s), 6'(m)});
                rd(2'd1, v);
                chk("R6", v, 16'(m));
                pend = sb & 6'(m);
                chk("R7", {15'd0, irq}, {15'd0, |pend});
                ev = 16'd0; oh = 6'd0;
                for (int i = 5; i >= 0; i--)
                    if (pend[i]) begin ev = 16'(i + 1); oh = 6'(1 << i); end
                rd(2'd2, v);
                chk("R8", v, ev);
                bus_busy = s[0];
                rd(2'd0, v);
                chk("R8 R3", v, 16'h8E00 | {3'd0, s[0], 6'd0, sb & ~oh});
                bus_busy = 1'b0;
            end
        end

        // R9 R10 R11 DMA configuration
        wr(2'd0, 16'h003F);
        wr(2'd1, 16'h003F);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v);
        chk("R9", v, 16'h8080);
        rd(2'd1, v);
        chk("R10", v, 16'h0027);
        pulse(16'h0008);
        chk("R11 rx", {14'd0, dma_rx_req, dma_tx_req}, 16'h2);
        pulse(16'h0010);
        chk("R11 both", {14'd0, dma_rx_req, dma_tx_req}, 16'h3);
        wr(2'd1, 16'h003F);
        wr(2'd3, 16'h0080);
        rd(2'd1, v);
        chk("R10 tx only", v, 16'h002F);
        chk("R11 rx off", {14'd0, dma_rx_req, dma_tx_req}, 16'h1);
        wr(2'd3, 16'h0000);
        rd(2'd1, v);
        chk("R10 zero", v, 16'h002F);
        chk("R11 off", {14'd0, dma_rx_req, dma_tx_req}, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule